// File: doc/BRIEF.md
# Buffered Synchronous Serial Channel

This block is one synchronous serial channel with an eight-slot byte buffer. The host fills the slots through a small register port, writes a control word that holds the byte count, the clock role, the chip-select option and the clock rate, and then issues a start. The channel moves one to eight bytes in sequence with no further host action. Each received byte is stored back into the slot its outgoing byte came from, so after completion the slots hold the incoming data. A one-cycle completion pulse marks the end.

As master, the channel generates the serial clock from the system clock at one of four rates. As slave, it follows an external serial clock. That clock is brought into the system clock domain through a two-flop stage and is then edge-detected. The serial clock idles high. The outgoing bit is updated on each falling serial-clock edge, and the incoming bit is sampled on each rising edge, most significant bit first. In chip-select mode the transfer proceeds only while the active-low select is low. The serial clock and data-out drivers are released whenever the select is high, and raising the select during a transfer abandons it.

The control state machine has six states:
- IDLE waits for a start and moves to WAIT_SEL.
- WAIT_SEL moves to LOAD once the channel is selected.
- LOAD copies the current slot into the shift register and moves to SHIFT.
- SHIFT moves eight bits and goes to STORE after the eighth rising edge.
- STORE writes the received byte back. It returns to LOAD for the next slot, or goes to FINISH after the last one.
- FINISH raises the completion pulse and returns to IDLE.

From LOAD, SHIFT or STORE, a deselect in chip-select mode sends the machine straight back to IDLE.

Two channels are obtained by instantiating the block twice.

Top module: `fifo_serial_unit`

## Requirements
- R1: After reset, sck_o and so are 1, done_irq is 0, the control word reads 0, the busy bit reads 0, sck_oe is 0 and so_oe is 1.
- R2: Host addresses 0 to 7 write and read buffer slots 0 to 7. Address 8 is the control word, with bits [2:0] holding the byte count minus one, bit 3 set for master, bit 4 set for chip-select mode and bits [6:5] holding the rate. Address 8 reads back with bit 7 as 0. A write to address 9 issues a start, and a read of address 9 returns the busy flag in bit 0.
- R3: In master mode the serial clock idles at 1, and each of its low and high phases lasts 2^rate system cycles, so the slowest rate gives a 16-cycle period.
- R4: Bits leave on so most significant bit first, with so updated at each falling serial-clock edge. si is sampled at each rising edge.
- R5: A start moves count-minus-one plus one bytes from slot 0 upward, and each received byte overwrites the slot its sent byte came from.
- R6: The busy flag is 1 from the start until the transfer completes. done_irq is high for exactly one cycle after the last byte, and the busy flag reads 0 after that.
- R7: In slave mode sck_oe is 0 and the channel shifts on edges of sck_i seen through a two-flop synchroniser. The sck_i low and high phases must each last at least 6 system cycles.
- R8: In chip-select mode, while cs_n is 1 both sck_oe and so_oe are 0, and a start waits with busy set and no clock activity until cs_n goes low.
- R9: In chip-select mode, cs_n going high during a transfer returns the channel to idle without done_irq, and resets the bit counter. The slot being transferred keeps its old value, and the next start sends it again from its most significant bit.
- R10: Host writes to the slots and to the control word are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 4 | Host read address |
| rd_data | output | 8 | Host read data (combinational) |
| sck_i | input | 1 | Serial clock from pin |
| sck_o | output | 1 | Serial clock to pin |
| sck_oe | output | 1 | Serial clock driver enable |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Serial data out driver enable |
| cs_n | input | 1 | Active-low chip select |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
Master transfers are run at the fastest rate, an intermediate rate and the slowest rate, with one byte, three bytes and all eight bytes. This separates errors in phase length from errors in byte sequencing and in slot write-back. The byte patterns include single set bits at either end and inverted pairs, so that bit order and off-by-one sampling show up. A slave transfer driven from an external clock model checks the synchroniser path. Three chip-select sequences are also run: a start while deselected, a deselect in the middle of a transfer followed by a fresh start, and host writes issued while busy. Together they separate waiting, abort with counter reset, and write blocking.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
    localparam int FSU_DEPTH  = 8;
    localparam int FSU_DATA_W = 8;
    localparam int FSU_IDX_W  = $clog2(FSU_DEPTH);
    localparam int FSU_RATE_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SEL,
        ST_LOAD,
        ST_SHIFT,
        ST_STORE,
        ST_FINISH
    } fsu_state_e;

    typedef struct packed {
        logic [FSU_RATE_W-1:0] rate;
        logic                  cs_mode;
        logic                  master;
        logic [FSU_IDX_W-1:0]  last;
    } fsu_ctrl_t;

    localparam int FSU_CTRL_W = $bits(fsu_ctrl_t);
endpackage

// File: rtl/fsu_slot_store.sv
module fsu_slot_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [IDX_W-1:0]  h_idx,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              e_we,
    input  logic [IDX_W-1:0]  e_idx,
    input  logic [DATA_W-1:0] e_wdata,
    input  logic [IDX_W-1:0]  h_ridx,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [IDX_W-1:0]  e_ridx,
    output logic [DATA_W-1:0] e_rdata
);
    logic [DEPTH-1:0][DATA_W-1:0] slots;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (e_we && e_idx == IDX_W'(g)) begin
                    q <= e_wdata;
                end else if (h_we && h_idx == IDX_W'(g)) begin
                    q <= h_wdata;
                end
            end
            assign slots[g] = q;
        end
    endgenerate

    assign h_rdata = slots[h_ridx];
    assign e_rdata = slots[e_ridx];
endmodule

// File: rtl/fsu_rate_gen.sv
module fsu_rate_gen #(
    parameter int RATE_W = 2,
    localparam int CNT_W = (1 << RATE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   half;

    assign half = (CNT_W+1)'(1) << rate;
    assign tick = en && ({1'b0, cnt_q} == half - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    rate_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && rate != '0) |=> !tick);
endmodule

// File: rtl/fsu_pin_sync.sv
module fsu_pin_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl
);
    logic [1:0] stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage <= {2{RST_VAL}};
        end else begin
            stage <= {stage[0], pin};
        end
    end

    assign lvl = stage[1];
endmodule

// File: rtl/fifo_serial_unit.sv
module fifo_serial_unit
    import fsu_pkg::*;
#(
    parameter int DATA_W = FSU_DATA_W,
    localparam int IDX_W  = FSU_IDX_W,
    localparam int ADDR_W = FSU_IDX_W + 1,
    localparam int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic              cs_n,
    output logic              done_irq
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(FSU_DEPTH);
    localparam logic [ADDR_W-1:0] START_ADDR = ADDR_W'(FSU_DEPTH + 1);

    fsu_state_e        state_q, state_d;
    fsu_ctrl_t         ctrl_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shreg_q;
    logic              sck_q, so_q, sck_prev_q;

    logic sck_lvl, cs_lvl, tick;
    logic idle, busy_w, selected, abort;
    logic start_req, ctrl_we, slot_we;
    logic fall_ev, rise_ev, shifting;
    logic [DATA_W-1:0] h_rdata, e_rdata;

    fsu_pin_sync #(.RST_VAL(1'b1)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .pin(sck_i), .lvl(sck_lvl)
    );

    fsu_pin_sync #(.RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .pin(cs_n), .lvl(cs_lvl)
    );

    fsu_rate_gen #(.RATE_W(FSU_RATE_W)) u_rate (
        .clk(clk), .rst_n(rst_n),
        .en(shifting && ctrl_q.master && !abort),
        .rate(ctrl_q.rate), .tick(tick)
    );

    fsu_slot_store #(.DEPTH(FSU_DEPTH), .DATA_W(DATA_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .h_we(slot_we), .h_idx(wr_addr[IDX_W-1:0]), .h_wdata(wr_data),
        .e_we(state_q == ST_STORE && !abort), .e_idx(idx_q), .e_wdata(shreg_q),
        .h_ridx(rd_addr[IDX_W-1:0]), .h_rdata(h_rdata),
        .e_ridx(idx_q), .e_rdata(e_rdata)
    );

    // Host decode: writes only take effect while idle
    assign idle      = (state_q == ST_IDLE);
    assign busy_w    = !idle;
    assign slot_we   = wr_en && idle && !wr_addr[ADDR_W-1];
    assign ctrl_we   = wr_en && idle && (wr_addr == CTRL_ADDR);
    assign start_req = wr_en && idle && (wr_addr == START_ADDR);

    // Chip-select qualification
    assign selected = !ctrl_q.cs_mode || !cs_lvl;
    assign abort    = ctrl_q.cs_mode && cs_lvl;

    // Shift events: internal divider ticks or synchronised external edges
    assign shifting = (state_q == ST_SHIFT);
    always_comb begin
        if (ctrl_q.master) begin
            fall_ev = shifting && tick && sck_q;
            rise_ev = shifting && tick && !sck_q;
        end else begin
            fall_ev = shifting && !sck_lvl && sck_prev_q;
            rise_ev = shifting && sck_lvl && !sck_prev_q;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_req) state_d = ST_WAIT_SEL;
            ST_WAIT_SEL: if (selected) state_d = ST_LOAD;
            ST_LOAD:     state_d = abort ? ST_IDLE : ST_SHIFT;
            ST_SHIFT: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (rise_ev && bit_q == '1) begin
                    state_d = ST_STORE;
                end
            end
            ST_STORE: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (idx_q == ctrl_q.last) begin
                    state_d = ST_FINISH;
                end else begin
                    state_d = ST_LOAD;
                end
            end
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            idx_q      <= '0;
            bit_q      <= '0;
            shreg_q    <= '0;
            sck_q      <= 1'b1;
            so_q       <= 1'b1;
            sck_prev_q <= 1'b1;
        end else begin
            sck_prev_q <= sck_lvl;
            if (ctrl_we) begin
                ctrl_q <= fsu_ctrl_t'(wr_data[FSU_CTRL_W-1:0]);
            end
            case (state_q)
                ST_IDLE: begin
                    if (start_req) idx_q <= '0;
                end
                ST_LOAD: begin
                    shreg_q <= e_rdata;
                    bit_q   <= '0;
                end
                ST_SHIFT: begin
                    if (fall_ev) so_q <= shreg_q[DATA_W-1];
                    if (rise_ev) begin
                        shreg_q <= {shreg_q[DATA_W-2:0], si};
                        bit_q   <= bit_q + 1'b1;
                    end
                    if (tick) sck_q <= !sck_q;
                end
                ST_STORE: begin
                    if (idx_q != ctrl_q.last) idx_q <= idx_q + 1'b1;
                end
                default: ;
            endcase
            if (state_d == ST_IDLE) begin
                sck_q <= 1'b1;
                bit_q <= '0;
            end
        end
    end

    // Pin and host outputs
    assign sck_o    = sck_q;
    assign so       = so_q;
    assign sck_oe   = ctrl_q.master && selected;
    assign so_oe    = selected;
    assign done_irq = (state_q == ST_FINISH);

    always_comb begin
        if (!rd_addr[ADDR_W-1]) begin
            rd_data = h_rdata;
        end else if (rd_addr == CTRL_ADDR) begin
            rd_data = DATA_W'(ctrl_q);
        end else if (rd_addr == START_ADDR) begin
            rd_data = DATA_W'(busy_w);
        end else begin
            rd_data = '0;
        end
    end

    // R6
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !busy_w);

    // R3
    sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> sck_q);

    // R9
    cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shifting && ctrl_q.cs_mode && cs_lvl) |=> idle);

    // R10
    busy_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && wr_en && wr_addr == CTRL_ADDR) |=> $stable(ctrl_q));

    // R5
    store_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STORE) |-> $past(state_q) == ST_SHIFT);
endmodule

// File: tb/fifo_serial_unit_bench.sv
`timescale 1ns/1ps
module fifo_serial_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;
    logic       sck_i, sck_o, sck_oe, si, so, so_oe, cs_n, done_irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] peer_send [8];
    logic [7:0] peer_got  [8];
    logic [7:0] slot_pat  [8];
    int half_meas, done_cnt, oe_at_fall, busy_at_fall;

    always #5 clk = ~clk;

    fifo_serial_unit u_fifo_serial_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sck_i(sck_i), .sck_o(sck_o),
        .sck_oe(sck_oe), .si(si), .so(so), .so_oe(so_oe), .cs_n(cs_n),
        .done_irq(done_irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic load_slots(input int n);
        for (int i = 0; i < n; i++) host_write(4'(i), slot_pat[i]);
    endtask

    function automatic logic [7:0] ctrl_word(input int rate, input int csm, input int mst,
                                             input int n);
        return 8'((rate << 5) | (csm << 4) | (mst << 3) | (n - 1));
    endfunction

    // Behaves as the far end for a master transfer; stop_falls > 0 returns early
    task automatic peer_master(input int nbytes, input int stop_falls);
        logic prev;
        int bits, falls, cyc, t_fall;
        prev = sck_o; bits = 0; falls = 0; cyc = 0; t_fall = 0;
        done_cnt = 0; half_meas = -1;
        rd_addr = 4'd9;
        while (cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (done_irq) done_cnt++;
            if (prev && !sck_o) begin
                falls++;
                if (falls == 1) begin
                    t_fall = cyc; oe_at_fall = int'(sck_oe); busy_at_fall = int'(rd_data[0]);
                end
                si = peer_send[bits / 8][7 - (bits % 8)];
            end
            if (!prev && sck_o) begin
                if (bits == 0) half_meas = cyc - t_fall;
                peer_got[bits / 8][7 - (bits % 8)] = so;
                bits++;
            end
            prev = sck_o;
            if (stop_falls > 0 && falls == stop_falls) break;
            if (bits == nbytes * 8 && done_cnt > 0) break;
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (done_irq) done_cnt++;
        end
    endtask

    task automatic test_reset;
        logic [7:0] d;
        chk("R1", "sck_o", sck_o, 1);
        chk("R1", "so", so, 1);
        chk("R1", "done_irq", done_irq, 0);
        chk("R1", "sck_oe", sck_oe, 0);
        chk("R1", "so_oe", so_oe, 1);
        host_read(4'd8, d); chk("R1", "control", d, 8'h00);
        host_read(4'd9, d); chk("R1", "busy", d, 8'h00);
    endtask

    task automatic test_map;
        logic [7:0] d;
        for (int i = 0; i < 8; i++) host_write(4'(i), 8'(i * 8'h11 + 3));
        for (int i = 0; i < 8; i++) begin
            host_read(4'(i), d);
            chk("R2", $sformatf("slot %0d", i), d, 8'(i * 8'h11 + 3));
        end
        host_write(4'd8, 8'hFF);
        host_read(4'd8, d); chk("R2", "control bit7 masked", d, 8'h7F);
        host_write(4'd8, 8'h00);
    endtask

    task automatic test_master(input int rate, input int n);
        logic [7:0] d;
        load_slots(n);
        host_write(4'd8, ctrl_word(rate, 0, 1, n));
        host_write(4'd9, 8'h00);
        peer_master(n, 0);
        chk("R3", $sformatf("half period rate %0d", rate), half_meas, 1 << rate);
        chk("R6", "busy during transfer", busy_at_fall, 1);
        chk("R6", "done pulse count", done_cnt, 1);
        for (int i = 0; i < n; i++)
            chk("R4", $sformatf("byte %0d sent msb first", i), peer_got[i], slot_pat[i]);
        for (int i = 0; i < n; i++) begin
            host_read(4'(i), d);
            chk("R5", $sformatf("slot %0d holds received", i), d, peer_send[i]);
        end
        host_read(4'd9, d); chk("R6", "busy clear after done", d, 8'h00);
    endtask

    task automatic test_slave;
        logic [7:0] d;
        slot_pat[0] = 8'h96; slot_pat[1] = 8'h0F;
        peer_send[0] = 8'hE1; peer_send[1] = 8'h2D;
        load_slots(2);
        host_write(4'd8, ctrl_word(0, 0, 0, 2));
        chk("R7", "sck_oe in slave", sck_oe, 0);
        host_write(4'd9, 8'h00);
        done_cnt = 0;
        wait_cycles(2);
        for (int b = 0; b < 2; b++) begin
            for (int k = 7; k >= 0; k--) begin
                @(negedge clk);
                sck_i = 1'b0; si = peer_send[b][k];
                wait_cycles(8);
                peer_got[b][k] = so;
                sck_i = 1'b1;
                wait_cycles(8);
            end
        end
        wait_cycles(4);
        chk("R7", "slave byte 0 out", peer_got[0], 8'h96);
        chk("R7", "slave byte 1 out", peer_got[1], 8'h0F);
        chk("R6", "slave done pulse", done_cnt, 1);
        host_read(4'd0, d); chk("R7", "slave slot 0 in", d, 8'hE1);
        host_read(4'd1, d); chk("R7", "slave slot 1 in", d, 8'h2D);
    endtask

    task automatic test_busy_writes;
        logic [7:0] d;
        slot_pat[0] = 8'h55; slot_pat[1] = 8'h11; peer_send[0] = 8'hC3;
        load_slots(2);
        host_write(4'd8, ctrl_word(3, 0, 1, 1));
        host_write(4'd9, 8'h00);
        host_write(4'd1, 8'hEE);
        host_write(4'd8, 8'h00);
        peer_master(1, 0);
        chk("R4", "byte sent under busy writes", peer_got[0], 8'h55);
        host_read(4'd1, d); chk("R10", "slot write ignored", d, 8'h11);
        host_read(4'd8, d); chk("R10", "control write ignored", d, ctrl_word(3, 0, 1, 1));
        host_read(4'd0, d); chk("R5", "slot 0 received", d, 8'hC3);
    endtask

    task automatic test_cs_wait;
        logic [7:0] d;
        slot_pat[0] = 8'hA7; peer_send[0] = 8'h19;
        cs_n = 1'b1;
        load_slots(1);
        host_write(4'd8, ctrl_word(0, 1, 1, 1));
        host_write(4'd9, 8'h00);
        done_cnt = 0;
        wait_cycles(20);
        host_read(4'd9, d); chk("R8", "busy while deselected", d, 8'h01);
        chk("R8", "sck_oe deselected", sck_oe, 0);
        chk("R8", "so_oe deselected", so_oe, 0);
        chk("R8", "sck_o idle while waiting", sck_o, 1);
        chk("R8", "no done while waiting", done_cnt, 0);
        cs_n = 1'b0;
        peer_master(1, 0);
        chk("R8", "sck_oe once selected", oe_at_fall, 1);
        chk("R8", "byte sent after select", peer_got[0], 8'hA7);
        host_read(4'd0, d); chk("R8", "byte received after select", d, 8'h19);
    endtask

    task automatic test_abort;
        logic [7:0] d;
        slot_pat[0] = 8'h81; slot_pat[1] = 8'h7E;
        peer_send[0] = 8'hFF; peer_send[1] = 8'hFF;
        cs_n = 1'b0;
        load_slots(2);
        host_write(4'd8, ctrl_word(2, 1, 1, 2));
        host_write(4'd9, 8'h00);
        peer_master(2, 3);
        @(negedge clk);
        cs_n = 1'b1;
        done_cnt = 0;
        wait_cycles(8);
        host_read(4'd9, d); chk("R9", "busy after abort", d, 8'h00);
        chk("R9", "no done on abort", done_cnt, 0);
        chk("R9", "so_oe after abort", so_oe, 0);
        chk("R9", "sck_oe after abort", sck_oe, 0);
        host_read(4'd0, d); chk("R9", "slot 0 untouched", d, 8'h81);
        cs_n = 1'b0;
        peer_send[0] = 8'h4B;
        host_write(4'd8, ctrl_word(2, 1, 1, 1));
        host_write(4'd9, 8'h00);
        peer_master(1, 0);
        chk("R9", "restart sends full byte", peer_got[0], 8'h81);
        host_read(4'd0, d); chk("R9", "restart receives", d, 8'h4B);
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        sck_i = 1'b1; si = 1'b0; cs_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset;
        test_map;

        slot_pat[0] = 8'hA5; peer_send[0] = 8'h3C;
        test_master(0, 1);

        slot_pat[0] = 8'h12; slot_pat[1] = 8'h34; slot_pat[2] = 8'hF0;
        peer_send[0] = 8'h0F; peer_send[1] = 8'h80; peer_send[2] = 8'h01;
        test_master(1, 3);

        for (int i = 0; i < 8; i++) begin
            slot_pat[i]  = 8'(i * 8'h1D + 8'h07);
            peer_send[i] = ~slot_pat[i];
        end
        test_master(3, 8);

        test_slave;
        test_busy_writes;
        test_cs_wait;
        test_abort;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule